// File: doc/BRIEF.md
# Dual-Channel 12-Bit Converter Load Interface

This block is the digital front end of a two-channel 12-bit converter. A host writes each channel's code over an 8-bit bus in two pieces, a low byte and a high nibble. Each piece goes into one of four input registers, and the register is chosen by a 2-bit address. A write happens only while both the active-low select and the active-low write strobe are low. A separate active-low update control copies both input registers into the output (DAC) registers on one clock edge. Because of that, the two channels always change together, however the writes to them were spread out in time.

If update is held low during a write, the path becomes transparent. The addressed input register takes the new data, and the matching DAC register receives the merged code on the same edge. An active-low clear zeroes all registers. Every input pin first passes through one capture register on the system clock. A pin level present at one rising edge therefore has its effect at the next rising edge.

Top module: `dual_dac_loader`

## Requirements
- R1: While the captured clear is low, every input register and both DAC codes become zero on the next edge, whatever the other pins are. Clear takes priority over writes and updates.
- R2: A write to address 0 (channel A) or address 2 (channel B) stores all 8 bus bits as bits 7..0 of that channel's input register. The DAC output does not change unless update is also asserted.
- R3: A write to address 1 (channel A) or address 3 (channel B) stores bus bits 3..0 as bits 11..8 of that channel's input register. Bus bits 7..4 are ignored.
- R4: If the select or the write strobe is high, no input register changes.
- R5: A write to one half of a channel leaves the other half of that channel, and all of the other channel, unchanged.
- R6: With update low, both DAC registers load from their input registers on the same edge.
- R7: With update high, both DAC codes hold their values.
- R8: With update, select and write all low, the addressed channel's DAC code takes the newly written value on the same edge as its input register. The other channel takes the value of its own input register.
- R9: A pin level sampled at rising edge k shows at the outputs just after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Active-low clear of all registers |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| upd_n | input | 1 | Active-low update / transparent enable |
| addr | input | 2 | Register select: 0 A low, 1 A high, 2 B low, 3 B high |
| din | input | 8 | Parallel data bus |
| code_a | output | 12 | Channel A DAC code |
| code_b | output | 12 | Channel B DAC code |

## Verification
The assertions check on every cycle that the outputs hold while update is idle and that clear zeroes them. They also check that an update copies both input registers together, and that a high-nibble write keeps the low byte and drops the upper bus bits. A transparent low-byte write is checked to reach the output directly. Only the bench's scenarios can show the ordering effects. These are: a pending write that stays invisible across several cycles; a merge of halves written in separate cycles; the absence of any write when a strobe is high; and the exact edge on which a change first appears.

// File: rtl/dual_dac_loader.sv
module dual_dac_loader #(
  parameter int BUS_W = 8,
  parameter int HI_W  = 4
) (
  input  logic                  clk,
  input  logic                  clr_n,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic                  upd_n,
  input  logic [1:0]            addr,
  input  logic [BUS_W-1:0]      din,
  output logic [BUS_W+HI_W-1:0] code_a,
  output logic [BUS_W+HI_W-1:0] code_b
);
  localparam int CW = BUS_W + HI_W;

  logic             clr_q, cs_q, wr_q, upd_q;
  logic [1:0]       addr_q;
  logic [BUS_W-1:0] din_q;
  logic             armed;

  always_ff @(posedge clk) begin
    clr_q  <= clr_n;
    cs_q   <= cs_n;
    wr_q   <= wr_n;
    upd_q  <= upd_n;
    addr_q <= addr;
    din_q  <= din;
    if (!clr_q) armed <= 1'b1;
  end

  logic ld, upd;
  assign ld  = clr_q && !cs_q && !wr_q;
  assign upd = clr_q && !upd_q;

  logic [CW-1:0] in_q  [2];
  logic [CW-1:0] in_nx [2];
  logic [CW-1:0] dac_q [2];

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic sel_lo, sel_hi;
    assign sel_lo = ld && (addr_q == {ch[0], 1'b0});
    assign sel_hi = ld && (addr_q == {ch[0], 1'b1});
    assign in_nx[ch] = {sel_hi ? din_q[HI_W-1:0] : in_q[ch][CW-1:BUS_W],
                        sel_lo ? din_q           : in_q[ch][BUS_W-1:0]};

    always_ff @(posedge clk) begin
      if (!clr_q) begin
        in_q[ch]  <= '0;
        dac_q[ch] <= '0;
      end else begin
        in_q[ch] <= in_nx[ch];
        if (upd) dac_q[ch] <= in_nx[ch];
      end
    end
  end

  assign code_a = dac_q[0];
  assign code_b = dac_q[1];

  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!armed)
    !clr_q |=> (code_a == '0 && code_b == '0 && in_q[0] == '0 && in_q[1] == '0));

  a_r7_hold_without_update: assert property (@(posedge clk) disable iff (!armed)
    (clr_q && upd_q) |=> ($stable(code_a) && $stable(code_b)));

  a_r6_joint_update: assert property (@(posedge clk) disable iff (!armed)
    (clr_q && !upd_q && (cs_q || wr_q)) |=>
      (code_a == $past(in_q[0]) && code_b == $past(in_q[1])));

  a_r3_high_nibble_only: assert property (@(posedge clk) disable iff (!armed)
    (clr_q && !cs_q && !wr_q && addr_q == 2'd1) |=>
      (in_q[0][CW-1:BUS_W] == $past(din_q[HI_W-1:0]) &&
       in_q[0][BUS_W-1:0] == $past(in_q[0][BUS_W-1:0])));

  a_r8_transparent_low: assert property (@(posedge clk) disable iff (!armed)
    (clr_q && !cs_q && !wr_q && !upd_q && addr_q == 2'd0) |=>
      (code_a[BUS_W-1:0] == $past(din_q) && code_b == $past(in_q[1])));

  a_r4_no_strobe_no_write: assert property (@(posedge clk) disable iff (!armed)
    (clr_q && (cs_q || wr_q)) |=> ($stable(in_q[0]) && $stable(in_q[1])));
endmodule

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;
  logic        clk = 1'b0;
  logic        clr_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1, upd_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  din = 8'd0;
  logic [11:0] code_a, code_b;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dual_dac_loader u_dual_dac_loader (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n), .upd_n(upd_n),
    .addr(addr), .din(din), .code_a(code_a), .code_b(code_b));

  // {req, clr_n, cs_n, wr_n, upd_n, addr, din, expected A, expected B}
  localparam int NV = 14;
  localparam logic [41:0] VEC [NV] = '{
    {4'd2, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h5A, 12'h000, 12'h000}, // R2 A low pending
    {4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'hF3, 12'h000, 12'h000}, // R3 A high pending
    {4'd6, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 12'h35A, 12'h000}, // R6 R3 upper bits dropped
    {4'd7, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 8'hC7, 12'h35A, 12'h000}, // R7
    {4'd7, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 8'h1E, 12'h35A, 12'h000}, // R7
    {4'd4, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 8'hFF, 12'h35A, 12'h000}, // R4 select high
    {4'd4, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 8'hFF, 12'h35A, 12'h000}, // R4 strobe high
    {4'd4, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 12'h35A, 12'hEC7}, // R4 R6 nothing leaked
    {4'd8, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'h01, 12'h301, 12'hEC7}, // R8 transparent A low
    {4'd8, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 8'h92, 12'h301, 12'h2C7}, // R8 transparent B high
    {4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'h0B, 12'h301, 12'h2C7}, // R5
    {4'd5, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 12'hB01, 12'h2C7}, // R5 low byte kept
    {4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'hAA, 12'h000, 12'h000}, // R1 clear wins
    {4'd1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00, 12'h000, 12'h000}  // R1 inputs cleared too
  };

  task automatic check(input int req, input logic [11:0] ea, input logic [11:0] eb);
    checks++;
    if (code_a !== ea || code_b !== eb) begin
      fails++;
      $display("FAIL R%0d: got A=%03h B=%03h expected A=%03h B=%03h",
               req, code_a, code_b, ea, eb);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic w, input logic u,
                       input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    clr_n = c; cs_n = s; wr_n = w; upd_n = u; addr = a; din = d;
  endtask

  task automatic idle_and_settle();
    @(negedge clk);
    clr_n = 1'b1; cs_n = 1'b1; wr_n = 1'b1; upd_n = 1'b1;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 8'h00);
    idle_and_settle();
    check(1, 12'h000, 12'h000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:32], VEC[i][31:24]);
      idle_and_settle();
      check(int'(VEC[i][41:38]), VEC[i][23:12], VEC[i][11:0]);
    end

    // R6 R9: pending on both channels, then one update; both move on the same edge
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'h44);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 8'h77);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
    @(negedge clk);
    upd_n = 1'b1;
    check(9, 12'h000, 12'h000);  // R9 update captured but not yet applied
    @(posedge clk);
    #2;
    check(6, 12'h044, 12'h077);  // R6 both together

    // R9 transparent write takes one extra edge after capture
    drive(1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 8'hF5);
    @(posedge clk);
    #2;
    check(9, 12'h044, 12'h077);
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1; upd_n = 1'b1;
    @(posedge clk);
    #2;
    check(8, 12'h044, 12'h577);

    // R2 pending B low write stays hidden over several cycles
    drive(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 8'h00);
    idle_and_settle();
    repeat (3) @(posedge clk);
    #2;
    check(2, 12'h044, 12'h577);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
    idle_and_settle();
    check(5, 12'h044, 12'h500);  // R5 high nibble of B kept

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule